// File: doc/BRIEF.md
# SPD EEPROM sequential byte reader

This block drives the register interface of an SMBus host controller to pull a run of bytes out of a serial-presence-detect EEPROM. A start pulse supplies a 7-bit slave address and a byte count. The first byte is fetched with a read-byte-data command that names offset zero. Each later byte is fetched with a receive-byte command that sends no offset, because the EEPROM advances its own address pointer after every access.

Before each command the sequencer clears the controller status. After the command it polls the status until the transfer is complete or a per-transaction cycle limit runs out. It then reads the data register. Every good byte leaves the block as a one-cycle strobe together with its index. A closing done pulse carries an error code, which is zero on success. Otherwise it is the status that stopped the run, with a separate flag when the limit expired.

Top module: `spd_seq_reader`

## Requirements
- R1: A start with a byte count of zero gives a done pulse on the cycle after start, with err_status 0 and err_timeout 0. It makes no register access at all.
- R2: The first transaction makes four writes in this order: 0xFF to status (address 0), 0x00 to offset (address 3), {slave_addr,1} to slave (address 4), and 0x48 to command (address 2).
- R3: Every later transaction makes exactly two writes, 0xFF to status (address 0) and then 0x44 to command (address 2). It writes neither the offset nor the slave register.
- R4: After a command write the status register (address 0) is read again and again while its bit 1 (done) is clear or its bit 0 (busy) is set. The data register (address 5) is read only once a status read has shown bit 1 set and bit 0 clear, unless the limit expired.
- R5: Each good byte appears as a one-cycle byte_valid pulse, with byte_data taken from the data register. byte_index counts 0, 1, … count-1 in order.
- R6: After the last byte of a run that succeeds, exactly one done pulse follows on a later cycle, with err_status 0 and err_timeout 0.
- R7: If a finished transaction's status is anything other than exactly 0x02, no byte is emitted for it and no further command is issued. done pulses with err_status set to that status and err_timeout 0.
- R8: The data register is read once per transaction even when the transaction fails or times out.
- R9: If TMO_CYC cycles pass after a command write without a ready status, the run aborts. done pulses with err_timeout 1 and err_status set to the last status that was read.
- R10: A start that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| slave_addr | input | 7 | EEPROM 7-bit bus address |
| byte_count | input | CNT_W | Number of bytes to fetch |
| busy | output | 1 | Run in progress |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_rd | output | 1 | Controller register read strobe (data returned next cycle) |
| ctl_addr | output | 3 | Controller register address |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data, valid the cycle after ctl_rd |
| byte_valid | output | 1 | One-cycle byte strobe |
| byte_data | output | 8 | Fetched byte |
| byte_index | output | CNT_W | Position of the byte in the run |
| done | output | 1 | One-cycle end-of-run pulse |
| err_status | output | 8 | 0 on success, else the status that aborted |
| err_timeout | output | 1 | Run ended because the poll limit expired |

## Verification
The bench checks that the offset and slave registers are written only in the first transaction. A design that resent them, or that used the wrong command code after byte 0, would show extra writes or a wrong write order. Error statuses such as 0x06 are injected in the middle of a run. A design that tested only the done bit would emit the bad byte and go on issuing commands. A controller that never finishes exercises the limit: the run must end with the timeout flag and the busy status, after reading the data register. Both a zero count and a start that arrives during a run are used to catch a design that generates bus traffic or restarts when it should not.

// File: rtl/spd_rd_pkg.sv
package spd_rd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR,
        S_OFS,
        S_ADR,
        S_CMD,
        S_POLL_RD,
        S_POLL_WAIT,
        S_DATA_RD,
        S_DATA_WAIT,
        S_FIN
    } seq_state_e;

    // controller register map (decoded by the host controller)
    localparam logic [2:0] REG_STAT = 3'd0;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_OFS  = 3'd3;
    localparam logic [2:0] REG_ADR  = 3'd4;
    localparam logic [2:0] REG_DATA = 3'd5;

    localparam logic [7:0] CMD_RD_DATA = 8'h48;
    localparam logic [7:0] CMD_RECV    = 8'h44;
    localparam logic [7:0] STAT_CLEAR  = 8'hFF;
    localparam logic [7:0] STAT_GOOD   = 8'h02;

endpackage

// File: rtl/spd_rd_stat_eval.sv
module spd_rd_stat_eval
    import spd_rd_pkg::*;
(
    input  logic [7:0] stat,
    output logic       ready,
    output logic       good
);
    // bit 1: transfer complete, bit 0: controller busy
    always_comb begin
        ready = stat[1] && !stat[0];
        good  = (stat == STAT_GOOD);
    end
endmodule

// File: rtl/spd_rd_timer.sv
module spd_rd_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = (cnt_q == LIM);
        cnt_d   = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired); // R9
endmodule

// File: rtl/spd_seq_reader.sv
module spd_seq_reader
    import spd_rd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TMO_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       slave_addr,
    input  logic [CNT_W-1:0] byte_count,
    output logic             busy,
    output logic             ctl_wr,
    output logic             ctl_rd,
    output logic [2:0]       ctl_addr,
    output logic [7:0]       ctl_wdata,
    input  logic [7:0]       ctl_rdata,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic [CNT_W-1:0] byte_index,
    output logic             done,
    output logic [7:0]       err_status,
    output logic             err_timeout
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
        logic [6:0]       addr;
        logic             first;
        logic [7:0]       stat;
        logic             tmo;
        logic             bv;
        logic [7:0]       bdata;
        logic [CNT_W-1:0] bidx;
        logic             dn;
        logic [7:0]       err;
        logic             etmo;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic rd_ready, rd_good_unused;
    logic st_ready_unused, st_good;
    logic tmr_clr, tmr_en, tmr_expired;

    spd_rd_stat_eval u_eval_live (
        .stat  (ctl_rdata),
        .ready (rd_ready),
        .good  (rd_good_unused)
    );

    spd_rd_stat_eval u_eval_held (
        .stat  (r_q.stat),
        .ready (st_ready_unused),
        .good  (st_good)
    );

    spd_rd_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .expired (tmr_expired)
    );

    assign tmr_clr = (r_q.st == S_CMD);
    assign tmr_en  = (r_q.st == S_POLL_RD) || (r_q.st == S_POLL_WAIT);

    // controller access, decoded from the current state
    always_comb begin
        ctl_wr    = 1'b0;
        ctl_rd    = 1'b0;
        ctl_addr  = REG_STAT;
        ctl_wdata = 8'h00;
        case (r_q.st)
            S_CLR:     begin ctl_wr = 1'b1; ctl_addr = REG_STAT; ctl_wdata = STAT_CLEAR; end
            S_OFS:     begin ctl_wr = 1'b1; ctl_addr = REG_OFS;  ctl_wdata = 8'h00; end
            S_ADR:     begin ctl_wr = 1'b1; ctl_addr = REG_ADR;  ctl_wdata = {r_q.addr, 1'b1}; end
            S_CMD:     begin
                ctl_wr    = 1'b1;
                ctl_addr  = REG_CMD;
                ctl_wdata = r_q.first ? CMD_RD_DATA : CMD_RECV;
            end
            S_POLL_RD: begin ctl_rd = 1'b1; ctl_addr = REG_STAT; end
            S_DATA_RD: begin ctl_rd = 1'b1; ctl_addr = REG_DATA; end
            default:   ;
        endcase
    end

    // next-state computation
    always_comb begin
        r_d    = r_q;
        r_d.bv = 1'b0;
        r_d.dn = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (byte_count == '0) begin
                        r_d.dn   = 1'b1;
                        r_d.err  = 8'h00;
                        r_d.etmo = 1'b0;
                    end else begin
                        r_d.st    = S_CLR;
                        r_d.cnt   = byte_count;
                        r_d.addr  = slave_addr;
                        r_d.idx   = '0;
                        r_d.first = 1'b1;
                    end
                end
            end
            S_CLR:     r_d.st = r_q.first ? S_OFS : S_CMD;
            S_OFS:     r_d.st = S_ADR;
            S_ADR:     r_d.st = S_CMD;
            S_CMD: begin
                r_d.tmo = 1'b0;
                r_d.st  = S_POLL_RD;
            end
            S_POLL_RD: r_d.st = S_POLL_WAIT;
            S_POLL_WAIT: begin
                r_d.stat = ctl_rdata;
                if (rd_ready) begin
                    r_d.st = S_DATA_RD;
                end else if (tmr_expired) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = S_DATA_RD;
                end else begin
                    r_d.st = S_POLL_RD;
                end
            end
            S_DATA_RD: r_d.st = S_DATA_WAIT;
            S_DATA_WAIT: begin
                if (st_good && !r_q.tmo) begin
                    r_d.bv    = 1'b1;
                    r_d.bdata = ctl_rdata;
                    r_d.bidx  = r_q.idx;
                    if (r_q.idx == r_q.cnt - 1'b1) begin
                        r_d.err  = 8'h00;
                        r_d.etmo = 1'b0;
                        r_d.st   = S_FIN;
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.first = 1'b0;
                        r_d.st    = S_CLR;
                    end
                end else begin
                    r_d.err  = r_q.stat;
                    r_d.etmo = r_q.tmo;
                    r_d.st   = S_FIN;
                end
            end
            S_FIN: begin
                r_d.dn = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, cnt: '0, idx: '0, addr: '0, first: 1'b0,
                     stat: '0, tmo: 1'b0, bv: 1'b0, bdata: '0, bidx: '0,
                     dn: 1'b0, err: '0, etmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != S_IDLE);
    assign byte_valid  = r_q.bv;
    assign byte_data   = r_q.bdata;
    assign byte_index  = r_q.bidx;
    assign done        = r_q.dn;
    assign err_status  = r_q.err;
    assign err_timeout = r_q.etmo;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ctl_wr || ctl_rd)); // R1
    AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !done); // R5
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_index < r_q.cnt)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_TMO_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_timeout) |-> (err_status != STAT_GOOD)); // R9
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_status != 8'h00) |-> !byte_valid); // R7

endmodule

// File: tb/spd_seq_reader_tb_top.sv
module spd_seq_reader_tb_top;

    localparam int CW  = 8;
    localparam int TMO = 30;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start = 1'b0;
    logic [6:0]    slave_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          busy, ctl_wr, ctl_rd, byte_valid, done, err_timeout;
    logic [2:0]    ctl_addr;
    logic [7:0]    ctl_wdata, ctl_rdata, byte_data, err_status;
    logic [CW-1:0] byte_index;

    spd_seq_reader #(.CNT_W(CW), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .slave_addr(slave_addr),
        .byte_count(byte_count), .busy(busy), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_index(byte_index),
        .done(done), .err_status(err_status), .err_timeout(err_timeout)
    );

    int checks = 0;
    int failures = 0;

    // controller model and logs
    logic [7:0] m_stat = 0, m_ofs = 0, m_data = 0, m_rd = 0;
    int m_ptr = 0, m_lat = 0, m_cur = 0, txn_n = 0;
    int fail_at = -1, hang_at = -1;
    logic [7:0] fail_val = 8'h06;
    int wr_n = 0, rd_n = 0, stat_rd_n = 0, data_rd_n = 0, bad_order = 0;
    logic last_ready = 1'b0;
    logic [2:0] wr_a [64];
    logic [7:0] wr_d [64];
    int got_n = 0, done_n = 0;
    logic [7:0] got_d [64];
    int got_i [64];
    logic [7:0] last_err = 0;
    logic last_tmo = 0;

    function automatic logic [7:0] mem_at(int i);
        return 8'((i * 37 + 5) & 255) ^ 8'hA5;
    endfunction

    assign ctl_rdata = m_rd;

    always @(posedge clk) begin
        if (m_lat > 0) begin
            m_lat = m_lat - 1;
            if (m_lat == 0) begin
                if (m_cur == hang_at)      m_stat = 8'h01;
                else if (m_cur == fail_at) m_stat = fail_val;
                else                       m_stat = 8'h02;
                m_data = mem_at(m_ptr);
                m_ptr  = m_ptr + 1;
                if (m_cur == hang_at) m_lat = 0;
            end
        end
        if (ctl_rd) begin
            rd_n = rd_n + 1;
            if (ctl_addr == 3'd0) begin
                stat_rd_n = stat_rd_n + 1;
                m_rd = m_stat;
                last_ready = m_stat[1] && !m_stat[0];
            end else if (ctl_addr == 3'd5) begin
                data_rd_n = data_rd_n + 1;
                m_rd = m_data;
                if (!last_ready) bad_order = bad_order + 1;
                last_ready = 1'b0;
            end else m_rd = 8'h00;
        end
        if (ctl_wr) begin
            if (wr_n < 64) begin wr_a[wr_n] = ctl_addr; wr_d[wr_n] = ctl_wdata; end
            wr_n = wr_n + 1;
            case (ctl_addr)
                3'd0: m_stat = m_stat & ~ctl_wdata;
                3'd3: m_ofs = ctl_wdata;
                3'd2: begin
                    m_cur = txn_n;
                    txn_n = txn_n + 1;
                    m_stat = 8'h01;
                    m_lat = LAT;
                    if (ctl_wdata == 8'h48) m_ptr = int'(m_ofs);
                end
                default: ;
            endcase
        end
        if (byte_valid) begin
            if (got_n < 64) begin got_d[got_n] = byte_data; got_i[got_n] = int'(byte_index); end
            got_n = got_n + 1;
        end
        if (done) begin
            done_n = done_n + 1;
            last_err = err_status;
            last_tmo = err_timeout;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        wr_n = 0; rd_n = 0; stat_rd_n = 0; data_rd_n = 0; bad_order = 0;
        got_n = 0; txn_n = 0; fail_at = -1; hang_at = -1;
    endtask

    task automatic run(input logic [6:0] a, input int n);
        int d0;
        d0 = done_n;
        @(negedge clk);
        start = 1'b1; slave_addr = a; byte_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            if (done_n != d0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !byte_valid && !ctl_wr && !ctl_rd, "reset", int'(busy), 0);
    endtask

    task automatic t_zero();
        clear_logs();
        @(negedge clk);
        start = 1'b1; byte_count = '0; slave_addr = 7'h51;
        @(negedge clk);
        start = 1'b0;
        chk(done && err_status == 0 && !err_timeout, "R1 done", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(wr_n == 0 && rd_n == 0, "R1 no access", wr_n + rd_n, 0);
    endtask

    task automatic t_normal();
        int n = 4;
        bit ok;
        clear_logs();
        run(7'h50, n);
        chk(got_n == n, "R5 count", got_n, n);
        ok = 1;
        for (int i = 0; i < n; i++)
            if (got_d[i] != mem_at(i) || got_i[i] != i) ok = 0;
        chk(ok, "R5 data/index", int'(got_d[0]), int'(mem_at(0)));
        chk(wr_a[0] == 0 && wr_d[0] == 8'hFF && wr_a[1] == 3 && wr_d[1] == 8'h00 &&
            wr_a[2] == 4 && wr_d[2] == 8'hA1 && wr_a[3] == 2 && wr_d[3] == 8'h48,
            "R2 first sequence", int'(wr_d[3]), 'h48);
        ok = 1;
        for (int t = 1; t < n; t++)
            if (wr_a[2+2*t] != 0 || wr_d[2+2*t] != 8'hFF ||
                wr_a[3+2*t] != 2 || wr_d[3+2*t] != 8'h44) ok = 0;
        chk(ok && wr_n == 4 + 2*(n-1), "R3 later sequence", wr_n, 4 + 2*(n-1));
        chk(bad_order == 0 && stat_rd_n >= 2*n, "R4 polling", stat_rd_n, 2*n);
        chk(done_n > 0 && last_err == 0 && !last_tmo, "R6 success", int'(last_err), 0);
    endtask

    task automatic t_single();
        clear_logs();
        run(7'h52, 1);
        chk(got_n == 1 && got_d[0] == mem_at(0), "R6 single byte", got_n, 1);
        chk(wr_n == 4 && last_err == 0, "R6 single writes", wr_n, 4);
    endtask

    task automatic t_error();
        clear_logs();
        fail_at = 2; fail_val = 8'h06;
        run(7'h53, 5);
        chk(got_n == 2, "R7 bytes before abort", got_n, 2);
        chk(last_err == 8'h06 && !last_tmo, "R7 err status", int'(last_err), 6);
        chk(txn_n == 3, "R7 no further cmd", txn_n, 3);
        chk(data_rd_n == 3, "R8 data read on error", data_rd_n, 3);
    endtask

    task automatic t_timeout();
        clear_logs();
        hang_at = 1;
        run(7'h54, 3);
        chk(got_n == 1, "R9 bytes before timeout", got_n, 1);
        chk(last_tmo && last_err == 8'h01, "R9 timeout flag", int'(last_err), 1);
        chk(data_rd_n == 2, "R8 data read on timeout", data_rd_n, 2);
        chk(txn_n == 2, "R9 no further cmd", txn_n, 2);
    endtask

    task automatic t_busy_start();
        int d0;
        clear_logs();
        d0 = done_n;
        @(negedge clk);
        start = 1'b1; slave_addr = 7'h55; byte_count = CW'(3);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        start = 1'b1; slave_addr = 7'h11; byte_count = '0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done_n == d0, "R10 no early done", done_n - d0, 0);
        for (int k = 0; k < 20000; k++) begin
            if (done_n != d0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(got_n == 3 && done_n == d0 + 1 && wr_d[2] == 8'hAB, "R10 ignored start", got_n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_normal();
        t_single();
        t_error();
        t_timeout();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule